// File: doc/BRIEF.md
# Arithmetic Logic-Block Slice

This block models one logic block of a small programmable fabric. It holds a row of `N` logic elements that share one set of control signals. Each element has a 4-input lookup table, set by a 16-bit configuration word, and one output register. A shared mode input selects how the whole row works. In table mode, each element returns the configuration bit that its four data inputs select. In arithmetic mode, the row becomes a ripple adder/subtractor.

In arithmetic mode, data bit 0 of element `i` is bit `i` of operand A and data bit 1 is bit `i` of operand B. Element 0 holds the least significant bit. A shared add/subtract control picks the operation while the block runs. To subtract, the row inverts every B bit inside the block and forces the carry into element 0 high. The carry out of the top element leaves the block on its own port.

Every element register obeys the same shared controls: asynchronous clear, asynchronous preset, clock enable, synchronous clear and synchronous load. A synchronous load takes each register's value from the register one element below it. Element 0 takes its value from a chain input, so the registers form a shift chain.

Top module: `lab_arith_slice`

## Requirements
- R1: With `arith_mode`=1 and `add_nsub`=1, `{blk_cout, comb_out}` equals A + B + `blk_cin` over N+1 bits. A and B are the N-bit vectors whose bit `i` is `data_in[4i]` and `data_in[4i+1]`.
- R2: With `arith_mode`=1 and `add_nsub`=0, `comb_out` equals (A − B) mod 2^N and `blk_cout` is 1 exactly when A ≥ B. `blk_cin` has no effect.
- R3: With `arith_mode`=0, `comb_out[i]` equals `lut_cfg[16i + data_in[4i+3:4i]]` and `blk_cout` is 0. `add_nsub` and `blk_cin` have no effect.
- R4: While `aclr` is high, every bit of `reg_out` is 0 without waiting for a clock edge, even when `apre` is also high.
- R5: While `apre` is high and `aclr` is low, every bit of `reg_out` is 1 without waiting for a clock edge.
- R6: At a clock edge with `ena` low (and no asynchronous control active), `reg_out` keeps its value whatever `sclr`, `sload` and the data are.
- R7: At a clock edge with `ena` high and `sclr` high, `reg_out` becomes 0, even when `sload` is also high.
- R8: At a clock edge with `ena` high, `sclr` low and `sload` high, `reg_out[i]` takes the old `reg_out[i-1]` and `reg_out[0]` takes `chain_in`.
- R9: At a clock edge with `ena` high and both `sclr` and `sload` low, `reg_out` takes the value `comb_out` had just before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock |
| aclr | input | 1 | Asynchronous clear, active high; also serves as the block reset |
| apre | input | 1 | Asynchronous preset to 1, active high |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load from the register chain |
| ena | input | 1 | Clock enable for all synchronous actions |
| arith_mode | input | 1 | 0 = table mode, 1 = arithmetic mode |
| add_nsub | input | 1 | In arithmetic mode: 1 = add, 0 = subtract |
| blk_cin | input | 1 | Carry from the block below (used when adding) |
| chain_in | input | 1 | Shift-chain input to element 0 |
| data_in | input | 4*N | Four data inputs per element, element `i` at bits `4i+3:4i` |
| lut_cfg | input | 16*N | Table configuration, element `i` at bits `16i+15:16i` |
| comb_out | output | N | Combinational element outputs |
| reg_out | output | N | Registered element outputs |
| blk_cout | output | 1 | Carry out of the top element (0 in table mode) |

## Verification
The bench builds the block with the default `N`=4. This width keeps the operand space small, so random operands often reach the edge cases: equal operands, an operand of zero, and sums that wrap past 2^N. It also keeps the shift chain short enough that a load pattern walks right out of the row within a few cycles. Random mixes of the shared controls meet every priority pairing many times, and directed steps hold each asynchronous control across a clock edge.

// File: rtl/lab_pkg.sv
package lab_pkg;

    localparam int LUT_INPUTS = 4;
    localparam int LUT_SIZE   = 1 << LUT_INPUTS;

    typedef enum logic {
        MODE_TABLE = 1'b0,
        MODE_ARITH = 1'b1
    } le_mode_e;

    typedef struct packed {
        logic aclr;
        logic apre;
        logic sclr;
        logic sload;
        logic ena;
    } reg_ctrl_t;

    typedef struct packed {
        logic sum;
        logic carry;
    } bit_sum_t;

    function automatic logic lut_pick(input logic [LUT_SIZE-1:0] cfg,
                                      input logic [LUT_INPUTS-1:0] sel);
        return cfg[sel];
    endfunction

    function automatic bit_sum_t full_add(input logic a, input logic b, input logic c);
        bit_sum_t r;
        r.sum   = a ^ b ^ c;
        r.carry = (a & b) | (a & c) | (b & c);
        return r;
    endfunction

endpackage

// File: rtl/lab_le_comb.sv
module lab_le_comb
    import lab_pkg::*;
(
    input  le_mode_e                mode,
    input  logic                    invert_b,
    input  logic [LUT_INPUTS-1:0]   data,
    input  logic [LUT_SIZE-1:0]     cfg,
    input  logic                    cin,
    output logic                    f,
    output logic                    cout
);
    bit_sum_t add_r;

    always_comb begin
        add_r = full_add(data[0], data[1] ^ invert_b, cin);
        if (mode == MODE_ARITH) begin
            f    = add_r.sum;
            cout = add_r.carry;
        end else begin
            f    = lut_pick(cfg, data);
            cout = 1'b0;
        end
    end
endmodule

// File: rtl/lab_le_reg.sv
module lab_le_reg
    import lab_pkg::*;
(
    input  logic      clk,
    input  reg_ctrl_t ctrl,
    input  logic      d,
    input  logic      chain,
    output logic      q
);
    always_ff @(posedge clk or posedge ctrl.aclr or posedge ctrl.apre) begin
        if (ctrl.aclr)
            q <= 1'b0;
        else if (ctrl.apre)
            q <= 1'b1;
        else if (ctrl.ena) begin
            if (ctrl.sclr)
                q <= 1'b0;
            else if (ctrl.sload)
                q <= chain;
            else
                q <= d;
        end
    end
endmodule

// File: rtl/lab_arith_slice.sv
module lab_arith_slice
    import lab_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                    clk,
    input  logic                    aclr,
    input  logic                    apre,
    input  logic                    sclr,
    input  logic                    sload,
    input  logic                    ena,
    input  logic                    arith_mode,
    input  logic                    add_nsub,
    input  logic                    blk_cin,
    input  logic                    chain_in,
    input  logic [N*LUT_INPUTS-1:0] data_in,
    input  logic [N*LUT_SIZE-1:0]   lut_cfg,
    output logic [N-1:0]            comb_out,
    output logic [N-1:0]            reg_out,
    output logic                    blk_cout
);
    localparam int CHAIN_W = N + 1;

    le_mode_e             mode;
    reg_ctrl_t            ctrl;
    logic                 subtract;
    logic [CHAIN_W-1:0]   carry;
    logic [N:0]           shift_src;

    assign mode      = arith_mode ? MODE_ARITH : MODE_TABLE;
    assign subtract  = (mode == MODE_ARITH) && !add_nsub;
    assign carry[0]  = subtract ? 1'b1 : blk_cin;
    assign shift_src = {reg_out, chain_in};
    assign ctrl      = '{aclr: aclr, apre: apre, sclr: sclr, sload: sload, ena: ena};

    for (genvar i = 0; i < N; i++) begin : g_le
        lab_le_comb u_comb (
            .mode     (mode),
            .invert_b (subtract),
            .data     (data_in[i*LUT_INPUTS +: LUT_INPUTS]),
            .cfg      (lut_cfg[i*LUT_SIZE +: LUT_SIZE]),
            .cin      (carry[i]),
            .f        (comb_out[i]),
            .cout     (carry[i+1])
        );

        lab_le_reg u_reg (
            .clk   (clk),
            .ctrl  (ctrl),
            .d     (comb_out[i]),
            .chain (shift_src[i]),
            .q     (reg_out[i])
        );
    end

    assign blk_cout = carry[N];
endmodule

// File: rtl/lab_arith_slice_chk.sv
module lab_arith_slice_chk #(
    parameter int N = 4
) (
    input logic             clk,
    input logic             aclr,
    input logic             apre,
    input logic             sclr,
    input logic             sload,
    input logic             ena,
    input logic             arith_mode,
    input logic             add_nsub,
    input logic             blk_cin,
    input logic             chain_in,
    input logic [N*4-1:0]   data_in,
    input logic [N-1:0]     comb_out,
    input logic [N-1:0]     reg_out,
    input logic             blk_cout
);
    logic [N:0] op_a;
    logic [N:0] op_b;

    always_comb begin
        op_a = '0;
        op_b = '0;
        for (int i = 0; i < N; i++) begin
            op_a[i] = data_in[4*i];
            op_b[i] = data_in[4*i+1];
        end
    end

    p_add_sum_r1: assert property (@(posedge clk) disable iff (aclr)
        (arith_mode && add_nsub) |-> ({blk_cout, comb_out} == op_a + op_b + {{N{1'b0}}, blk_cin}));

    p_sub_borrow_r2: assert property (@(posedge clk) disable iff (aclr)
        (arith_mode && !add_nsub) |-> (blk_cout == (op_a >= op_b)));

    p_hold_r6: assert property (@(posedge clk) disable iff (aclr || apre)
        !ena |=> $stable(reg_out));

    p_sclr_r7: assert property (@(posedge clk) disable iff (aclr || apre)
        (ena && sclr) |=> (reg_out == '0));

    p_shift_r8: assert property (@(posedge clk) disable iff (aclr || apre)
        (ena && !sclr && sload) |=> (reg_out == {$past(reg_out[N-2:0]), $past(chain_in)}));

    p_capture_r9: assert property (@(posedge clk) disable iff (aclr || apre)
        (ena && !sclr && !sload) |=> (reg_out == $past(comb_out)));
endmodule

bind lab_arith_slice lab_arith_slice_chk #(.N(N)) u_chk (
    .clk        (clk),
    .aclr       (aclr),
    .apre       (apre),
    .sclr       (sclr),
    .sload      (sload),
    .ena        (ena),
    .arith_mode (arith_mode),
    .add_nsub   (add_nsub),
    .blk_cin    (blk_cin),
    .chain_in   (chain_in),
    .data_in    (data_in),
    .comb_out   (comb_out),
    .reg_out    (reg_out),
    .blk_cout   (blk_cout)
);

// File: tb/lab_arith_slice_tb.sv
module lab_arith_slice_tb;
    localparam int N          = 4;
    localparam int CLK_PERIOD = 10;
    localparam int MASK       = (1 << N) - 1;

    logic             clk = 1'b0;
    logic             aclr = 1'b1, apre = 1'b0, sclr = 1'b0, sload = 1'b0, ena = 1'b0;
    logic             arith_mode = 1'b0, add_nsub = 1'b1, blk_cin = 1'b0, chain_in = 1'b0;
    logic [N*4-1:0]   data_in = '0;
    logic [N*16-1:0]  lut_cfg = '0;
    logic [N-1:0]     comb_out, reg_out;
    logic             blk_cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [N-1:0] exp_q = '0;

    lab_arith_slice #(.N(N)) u_dut (
        .clk(clk), .aclr(aclr), .apre(apre), .sclr(sclr), .sload(sload), .ena(ena),
        .arith_mode(arith_mode), .add_nsub(add_nsub), .blk_cin(blk_cin), .chain_in(chain_in),
        .data_in(data_in), .lut_cfg(lut_cfg), .comb_out(comb_out), .reg_out(reg_out),
        .blk_cout(blk_cout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int opnd(input int bitpos);
        int v = 0;
        for (int i = 0; i < N; i++) v |= int'(data_in[4*i+bitpos]) << i;
        return v;
    endfunction

    // Expected {cout, comb} as one integer: bit N is the carry.
    function automatic int model_comb();
        int a = opnd(0);
        int b = opnd(1);
        int r = 0;
        if (arith_mode) begin
            if (add_nsub) r = a + b + int'(blk_cin);
            else          r = ((a - b) & MASK) | ((a >= b) ? (1 << N) : 0);
        end else begin
            for (int i = 0; i < N; i++)
                r |= int'(lut_cfg[16*i + int'(data_in[4*i +: 4])]) << i;
        end
        return r;
    endfunction

    // Inputs are already applied (just after a negedge); checks comb, clocks once, checks reg.
    task automatic step();
        int    ec;
        string ctag;
        string rtag;
        #1;
        ec = model_comb();
        ctag = !arith_mode ? "R3" : (add_nsub ? "R1" : "R2");
        check(ctag, {blk_cout, comb_out}, ec);
        if (!ena)       begin rtag = "R6"; end
        else if (sclr)  begin rtag = "R7"; exp_q = '0; end
        else if (sload) begin rtag = "R8"; exp_q = {exp_q[N-2:0], chain_in}; end
        else            begin rtag = "R9"; exp_q = ec[N-1:0]; end
        @(posedge clk);
        #1;
        check(rtag, reg_out, exp_q);
        @(negedge clk);
    endtask

    task automatic set_ops(input int a, input int b);
        for (int i = 0; i < N; i++) begin
            data_in[4*i]   = a[i];
            data_in[4*i+1] = b[i];
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 reset state", reg_out, 0);
        aclr = 1'b0;
        ena  = 1'b1;

        // R1 boundaries: full wrap with carry-in, zero sum
        arith_mode = 1'b1; add_nsub = 1'b1;
        set_ops(MASK, MASK); blk_cin = 1'b1; step();
        set_ops(0, 0);       blk_cin = 1'b0; step();
        // R2 boundaries: equal operands, zero minus max, blk_cin ignored
        add_nsub = 1'b0;
        set_ops(5, 5);    blk_cin = 1'b0; step();
        set_ops(0, MASK); blk_cin = 1'b1; step();
        set_ops(MASK, 0); blk_cin = 1'b1; step();
        // R3: table mode ignores add_nsub / blk_cin
        arith_mode = 1'b0; lut_cfg = {N{16'h8001}}; data_in = {N{4'hF}}; step();
        add_nsub = 1'b1; blk_cin = 1'b1; data_in = '0; step();

        // R7 beats R8
        sclr = 1'b1; sload = 1'b1; step();
        // R8 shift a one through the chain
        sclr = 1'b0; chain_in = 1'b1; step();
        chain_in = 1'b0;
        for (int k = 0; k < N; k++) step();
        // R6 with sclr pending
        sload = 1'b0; data_in = {N{4'hF}}; step();
        ena = 1'b0; sclr = 1'b1; step();
        sclr = 1'b0; ena = 1'b1;

        // R5: preset held across an edge
        @(negedge clk);
        apre = 1'b1; #1;
        check("R5 async preset", reg_out, MASK);
        @(posedge clk); #1;
        check("R5 preset held", reg_out, MASK);
        // R4: clear over preset
        aclr = 1'b1; #1;
        check("R4 clear over preset", reg_out, 0);
        @(negedge clk);
        apre = 1'b0; @(posedge clk); #1;
        check("R4 clear held", reg_out, 0);
        @(negedge clk);
        aclr = 1'b0;
        exp_q = '0;

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            arith_mode = ($urandom % 3) != 0;
            add_nsub   = $urandom;
            blk_cin    = $urandom;
            chain_in   = $urandom;
            data_in    = {$urandom, $urandom};
            lut_cfg    = {$urandom, $urandom};
            ena        = ($urandom % 4) != 0;
            sclr       = ($urandom % 10) == 0;
            sload      = ($urandom % 6) == 0;
            step();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule